// File: doc/BRIEF.md
# Completion Interrupt Coalescing Controller

This block decides, for every interrupt vector of a storage controller, the clock cycle in which that vector asks for an interrupt after completion entries are posted. Each completion queue is mapped to one vector through a small table, and several queues may share a vector. On a vector with coalescing enabled, the I/O completions mapped to it are gathered together. The vector fires once enough of them have built up, or once a window timer runs out. On a vector with coalescing disabled, every completion fires.

Queue 0 is the administrative completion queue. It is pinned to vector 0 and is never coalesced. An admin completion fires vector 0 at once, even when I/O queues that share vector 0 are being coalesced. That interrupt also covers any I/O completions gathered on vector 0, because the host drains every queue of a vector when it services that vector.

A fired vector stays in service until the host acknowledges it. A masked vector holds its completions and fires when the mask is removed. Changes to the threshold, the time or the enable are picked up when the next aggregation window opens.

Top module: `intr_coalesce_ctrl`

## Requirements
- R1: After reset, `irq_req` is all zero and no vector is in service. Coalescing is enabled on every vector, the threshold and the time are both 0, and queue q maps to vector q mod NUM_VEC.
- R2: A post with `post_qid` = 0 (the admin queue) fires vector 0 at the clock edge that accepts it, whatever the threshold, enable and pending count, provided vector 0 is neither masked nor in service. The same firing clears the I/O completions pending on vector 0.
- R3: A post to queue q counts on the vector held in map entry q. A map write (`map_wr`, `map_wr_qid`, `map_wr_vec`) replaces that entry. A map write to queue 0 is ignored, so admin posts never count on any other vector.
- R4: On a vector whose enable bit is 0, every accepted post fires the vector at the edge that accepts it.
- R5: On a coalescing vector, the edge that accepts the (threshold+1)-th pending completion fires the vector. Earlier edges do not fire it.
- R6: On a coalescing vector with a time setting T other than 0, the vector fires T*TICK_CYCLES edges after the edge that accepted the window's first completion, unless it has fired earlier. T = 0 turns the timer off.
- R7: `irq_req` is a one-cycle pulse. Firing clears the vector's count and timer and puts the vector in service. A vector in service does not fire again until an `irq_ack` bit for it has been sampled.
- R8: A masked vector never fires. Posts made while it is masked are kept, and the vector fires at the first edge at which it is unmasked.
- R9: Threshold, time and enable writes apply from the next aggregation window. A window that is already open keeps the settings it opened with, and no pending completion is dropped.
- R10: If posts arrived while a vector was in service, the vector fires at the first edge after the acknowledge has taken effect.
- R11: Completions from different queues that map to one vector are counted together toward its threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| post_valid | input | 1 | A completion entry is posted in this cycle |
| post_qid | input | QID_W | Queue ID of the posted completion (0 = admin) |
| map_wr | input | 1 | Write strobe for the queue-to-vector table |
| map_wr_qid | input | QID_W | Table entry to write |
| map_wr_vec | input | VEC_W | Vector to store in that entry |
| en_wr | input | 1 | Write strobe for the coalescing enable bits |
| en_val | input | NUM_VEC | Coalescing enable, one bit per vector |
| thr_wr | input | 1 | Write strobe for the aggregation threshold |
| thr_val | input | THR_W | Aggregation threshold (fire at threshold+1) |
| time_wr | input | 1 | Write strobe for the aggregation time |
| time_val | input | TIME_W | Aggregation time in units of TICK_CYCLES |
| irq_mask | input | NUM_VEC | Per-vector mask |
| irq_ack | input | NUM_VEC | Per-vector acknowledge, takes a vector out of service |
| irq_req | output | NUM_VEC | Per-vector interrupt request pulse |

## Verification
Every cause of firing except the timer and a release from service shows up on `irq_req` right after the rising edge that samples it: a post, the threshold count, an unmask. The timer fires exactly T*100 edges after the edge that accepted the first completion. A release from service fires one edge after the acknowledge edge. The bench changes inputs on falling edges and reads `irq_req` on the following falling edge. For the timer it checks every cycle of the window, and for the acknowledge release it checks both the acknowledge cycle (expected quiet) and the cycle after it. The threshold sweep covers every threshold from 0 to 3 on every vector, and each posting step predicts its result from threshold+1.

// File: rtl/icc_pkg.sv
package icc_pkg;

  // Number of clock cycles in a window of `units` time-base units.
  function automatic int unsigned tmo_cycles(input int unsigned units,
                                             input int unsigned tick);
    return units * tick;
  endfunction

  // Vector that queue q maps to after reset.
  function automatic int unsigned reset_vec(input int unsigned q,
                                            input int unsigned nvec);
    return q % nvec;
  endfunction

  // True once the pending count exceeds the threshold (count == threshold+1).
  function automatic logic thr_reached(input int unsigned cnt,
                                       input int unsigned thr);
    return cnt > thr;
  endfunction

  // True when the open window has run for its full time setting.
  function automatic logic tmo_reached(input int unsigned elapsed,
                                       input int unsigned units,
                                       input int unsigned tick);
    return (units != 0) && ((elapsed + 1) >= tmo_cycles(units, tick));
  endfunction

endpackage

// File: rtl/icc_cfg.sv
module icc_cfg #(
  parameter int unsigned NUM_VEC = 4,
  parameter int unsigned THR_W   = 8,
  parameter int unsigned TIME_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_wr,
  input  logic [NUM_VEC-1:0] en_val,
  input  logic               thr_wr,
  input  logic [THR_W-1:0]   thr_val,
  input  logic               time_wr,
  input  logic [TIME_W-1:0]  time_val,
  output logic [NUM_VEC-1:0] en_q,
  output logic [THR_W-1:0]   thr_q,
  output logic [TIME_W-1:0]  time_q
);
  // Each field has its own strobe so it can be written alone.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '1;
      thr_q  <= '0;
      time_q <= '0;
    end else begin
      if (en_wr)   en_q   <= en_val;
      if (thr_wr)  thr_q  <= thr_val;
      if (time_wr) time_q <= time_val;
    end
  end
endmodule

// File: rtl/icc_qmap.sv
module icc_qmap #(
  parameter int unsigned NUM_Q     = 8,
  parameter int unsigned NUM_VEC   = 4,
  parameter int unsigned ADMIN_QID = 0,
  localparam int unsigned QID_W    = $clog2(NUM_Q),
  localparam int unsigned VEC_W    = $clog2(NUM_VEC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               map_wr,
  input  logic [QID_W-1:0]   map_wr_qid,
  input  logic [VEC_W-1:0]   map_wr_vec,
  input  logic               post_valid,
  input  logic [QID_W-1:0]   post_qid,
  output logic [NUM_VEC-1:0] hit,
  output logic               adm_post
);
  import icc_pkg::*;

  logic [NUM_Q*VEC_W-1:0] map_flat;
  logic [VEC_W-1:0]       sel_vec;

  for (genvar q = 0; q < NUM_Q; q++) begin : g_ent
    if (q == ADMIN_QID) begin : g_admin
      // The admin queue stays on vector 0.
      assign map_flat[q*VEC_W +: VEC_W] = '0;
    end else begin : g_io
      logic [VEC_W-1:0] ent_q;
      always_ff @(posedge clk) begin
        if (!rst_n)
          ent_q <= VEC_W'(reset_vec(q, NUM_VEC));
        else if (map_wr && map_wr_qid == QID_W'(q))
          ent_q <= map_wr_vec;
      end
      assign map_flat[q*VEC_W +: VEC_W] = ent_q;
    end
  end

  always_comb begin
    sel_vec = '0;
    for (int q = 0; q < NUM_Q; q++)
      if (post_qid == QID_W'(q)) sel_vec = map_flat[q*VEC_W +: VEC_W];
  end

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_hit
    assign hit[v] = post_valid && (sel_vec == VEC_W'(v));
  end

  assign adm_post = post_valid && (post_qid == QID_W'(ADMIN_QID));
endmodule

// File: rtl/icc_vec_engine.sv
module icc_vec_engine #(
  parameter int unsigned THR_W       = 8,
  parameter int unsigned TIME_W      = 4,
  parameter int unsigned TICK_CYCLES = 100,
  localparam int unsigned CNT_W      = THR_W + 1,
  localparam int unsigned ELAP_W     = $clog2(((1 << TIME_W) - 1) * TICK_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit,
  input  logic              adm_hit,
  input  logic              mask,
  input  logic              ack,
  input  logic              cfg_en,
  input  logic [THR_W-1:0]  cfg_thr,
  input  logic [TIME_W-1:0] cfg_time,
  output logic              irq,
  output logic              busy,
  output logic              fire
);
  import icc_pkg::*;

  logic [CNT_W-1:0]  cnt_q, cnt_add;
  logic [ELAP_W-1:0] elap_q;
  logic              win_en_q;
  logic [THR_W-1:0]  win_thr_q;
  logic [TIME_W-1:0] win_time_q;
  logic              held_q, admp_q, busy_q;

  logic              open_win, blocked;
  logic              eff_en;
  logic [THR_W-1:0]  eff_thr;
  logic [TIME_W-1:0] eff_time;
  logic              thr_hit, nocoal_hit, tmo_hit, cause;

  // A window that is still closed takes the live settings; an open one keeps
  // the settings it was opened with.
  assign open_win = (cnt_q == '0);
  assign eff_en   = open_win ? cfg_en   : win_en_q;
  assign eff_thr  = open_win ? cfg_thr  : win_thr_q;
  assign eff_time = open_win ? cfg_time : win_time_q;

  assign cnt_add    = (hit && cnt_q != '1) ? cnt_q + CNT_W'(1) : cnt_q;
  assign thr_hit    = eff_en && thr_reached(32'(cnt_add), 32'(eff_thr));
  assign nocoal_hit = !eff_en && (cnt_add != '0);
  assign tmo_hit    = eff_en && !open_win &&
                      tmo_reached(32'(elap_q), 32'(eff_time), TICK_CYCLES);

  assign blocked = mask || busy_q;
  assign cause   = adm_hit || admp_q || thr_hit || nocoal_hit || tmo_hit || held_q;
  assign fire    = !blocked && cause;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      elap_q     <= '0;
      win_en_q   <= 1'b1;
      win_thr_q  <= '0;
      win_time_q <= '0;
      held_q     <= 1'b0;
      admp_q     <= 1'b0;
      busy_q     <= 1'b0;
      irq        <= 1'b0;
    end else if (fire) begin
      cnt_q  <= '0;
      elap_q <= '0;
      held_q <= 1'b0;
      admp_q <= 1'b0;
      busy_q <= 1'b1;
      irq    <= 1'b1;
    end else begin
      irq    <= 1'b0;
      cnt_q  <= cnt_add;
      held_q <= held_q || (blocked && hit);
      admp_q <= admp_q || adm_hit;
      if (ack) busy_q <= 1'b0;
      if (open_win) elap_q <= '0;
      else if (elap_q != '1) elap_q <= elap_q + ELAP_W'(1);
      if (open_win && hit) begin
        win_en_q   <= cfg_en;
        win_thr_q  <= cfg_thr;
        win_time_q <= cfg_time;
      end
    end
  end

  assign busy = busy_q;
endmodule

// File: rtl/intr_coalesce_ctrl.sv
module intr_coalesce_ctrl #(
  parameter int unsigned NUM_Q       = 8,
  parameter int unsigned NUM_VEC     = 4,
  parameter int unsigned THR_W       = 8,
  parameter int unsigned TIME_W      = 4,
  parameter int unsigned TICK_CYCLES = 100,
  localparam int unsigned QID_W      = $clog2(NUM_Q),
  localparam int unsigned VEC_W      = $clog2(NUM_VEC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               post_valid,
  input  logic [QID_W-1:0]   post_qid,
  input  logic               map_wr,
  input  logic [QID_W-1:0]   map_wr_qid,
  input  logic [VEC_W-1:0]   map_wr_vec,
  input  logic               en_wr,
  input  logic [NUM_VEC-1:0] en_val,
  input  logic               thr_wr,
  input  logic [THR_W-1:0]   thr_val,
  input  logic               time_wr,
  input  logic [TIME_W-1:0]  time_val,
  input  logic [NUM_VEC-1:0] irq_mask,
  input  logic [NUM_VEC-1:0] irq_ack,
  output logic [NUM_VEC-1:0] irq_req
);
  // Named internal events, brought out for the checker.
  logic [NUM_VEC-1:0] vec_hit;
  logic [NUM_VEC-1:0] vec_busy;
  logic [NUM_VEC-1:0] vec_fire;
  logic               adm_post;

  logic [NUM_VEC-1:0] en_q;
  logic [THR_W-1:0]   thr_q;
  logic [TIME_W-1:0]  time_q;

  icc_cfg #(.NUM_VEC(NUM_VEC), .THR_W(THR_W), .TIME_W(TIME_W)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .en_wr(en_wr), .en_val(en_val),
    .thr_wr(thr_wr), .thr_val(thr_val),
    .time_wr(time_wr), .time_val(time_val),
    .en_q(en_q), .thr_q(thr_q), .time_q(time_q)
  );

  icc_qmap #(.NUM_Q(NUM_Q), .NUM_VEC(NUM_VEC), .ADMIN_QID(0)) u_qmap (
    .clk(clk), .rst_n(rst_n),
    .map_wr(map_wr), .map_wr_qid(map_wr_qid), .map_wr_vec(map_wr_vec),
    .post_valid(post_valid), .post_qid(post_qid),
    .hit(vec_hit), .adm_post(adm_post)
  );

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
    logic adm_v;
    if (v == 0) begin : g_adm
      assign adm_v = adm_post;
    end else begin : g_noadm
      assign adm_v = 1'b0;
    end

    icc_vec_engine #(.THR_W(THR_W), .TIME_W(TIME_W), .TICK_CYCLES(TICK_CYCLES)) u_eng (
      .clk(clk), .rst_n(rst_n),
      .hit(vec_hit[v]), .adm_hit(adm_v),
      .mask(irq_mask[v]), .ack(irq_ack[v]),
      .cfg_en(en_q[v]), .cfg_thr(thr_q), .cfg_time(time_q),
      .irq(irq_req[v]), .busy(vec_busy[v]), .fire(vec_fire[v])
    );
  end
endmodule

// File: rtl/icc_checker.sv
module icc_checker #(
  parameter int unsigned NUM_VEC = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               adm_post,
  input logic [NUM_VEC-1:0] irq_mask,
  input logic [NUM_VEC-1:0] irq_req,
  input logic [NUM_VEC-1:0] vec_busy,
  input logic [NUM_VEC-1:0] vec_fire
);
  assert_admin_immediate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    adm_post && !irq_mask[0] && !vec_busy[0] |=> irq_req[0]);

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_chk
    assert_one_cycle_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req[v] |=> !irq_req[v]);

    assert_in_service_after_fire_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req[v] |-> vec_busy[v]);

    assert_busy_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
      vec_busy[v] |=> !irq_req[v]);

    assert_mask_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_mask[v] |-> !vec_fire[v]);

    assert_masked_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_mask[v] |=> !irq_req[v]);
  end
endmodule

bind intr_coalesce_ctrl icc_checker #(.NUM_VEC(NUM_VEC)) u_icc_chk (
  .clk(clk), .rst_n(rst_n), .adm_post(adm_post),
  .irq_mask(irq_mask), .irq_req(irq_req),
  .vec_busy(vec_busy), .vec_fire(vec_fire)
);

// File: tb/intr_coalesce_ctrl_bench.sv
module intr_coalesce_ctrl_bench;
  localparam int NQ = 8;
  localparam int NV = 4;
  localparam int QW = 3;
  localparam int VW = 2;
  localparam int TICK = 100;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          post_valid = 1'b0;
  logic [QW-1:0] post_qid = '0;
  logic          map_wr = 1'b0;
  logic [QW-1:0] map_wr_qid = '0;
  logic [VW-1:0] map_wr_vec = '0;
  logic          en_wr = 1'b0;
  logic [NV-1:0] en_val = '0;
  logic          thr_wr = 1'b0;
  logic [7:0]    thr_val = '0;
  logic          time_wr = 1'b0;
  logic [3:0]    time_val = '0;
  logic [NV-1:0] irq_mask = '0;
  logic [NV-1:0] irq_ack = '0;
  logic [NV-1:0] irq_req;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  intr_coalesce_ctrl u_intr_coalesce_ctrl (
    .clk(clk), .rst_n(rst_n),
    .post_valid(post_valid), .post_qid(post_qid),
    .map_wr(map_wr), .map_wr_qid(map_wr_qid), .map_wr_vec(map_wr_vec),
    .en_wr(en_wr), .en_val(en_val),
    .thr_wr(thr_wr), .thr_val(thr_val),
    .time_wr(time_wr), .time_val(time_val),
    .irq_mask(irq_mask), .irq_ack(irq_ack), .irq_req(irq_req)
  );

  task automatic chk(input string req, input logic [NV-1:0] got, input logic [NV-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: irq_req=%b expected=%b", req, got, exp);
    end
  endtask

  // Posts one completion; returns irq_req after the accepting edge.
  task automatic post(input int q, output logic [NV-1:0] got);
    post_valid = 1'b1;
    post_qid   = QW'(q);
    @(negedge clk);
    got = irq_req;
    post_valid = 1'b0;
  endtask

  task automatic ack_all();
    irq_ack = '1;
    @(negedge clk);
    irq_ack = '0;
  endtask

  task automatic set_thr(input int t);
    thr_wr = 1'b1; thr_val = 8'(t);
    @(negedge clk);
    thr_wr = 1'b0;
  endtask

  task automatic set_time(input int t);
    time_wr = 1'b1; time_val = 4'(t);
    @(negedge clk);
    time_wr = 1'b0;
  endtask

  task automatic set_en(input logic [NV-1:0] e);
    en_wr = 1'b1; en_val = e;
    @(negedge clk);
    en_wr = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: irq_req=%b expected=run complete", irq_req);
    finish_run();
  end

  initial begin
    logic [NV-1:0] g;
    int bad;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: outputs quiet out of reset; default map sends queue 5 to vector 1.
    chk("R1 reset quiet", irq_req, '0);
    post(5, g);
    chk("R1 R3 default map q5->v1 threshold 0", g, 4'b0010);
    ack_all();

    // R1: coalescing already enabled, so a threshold write alone takes effect.
    set_thr(2);
    post(1, g); chk("R1 R5 default enable post1", g, '0);
    post(1, g); chk("R1 R5 default enable post2", g, '0);
    post(1, g); chk("R1 R5 default enable post3", g, 4'b0010);
    ack_all();

    // R5: sweep thresholds 0..3 on every vector (queue v+4 maps to vector v).
    for (int t = 0; t < 4; t++) begin
      set_thr(t);
      for (int v = 0; v < NV; v++) begin
        for (int k = 1; k <= t + 1; k++) begin
          post(v + 4, g);
          chk("R5 threshold sweep", g, (k == t + 1) ? NV'(1 << v) : NV'(0));
        end
        ack_all();
      end
    end

    // R4: vector 1 with coalescing off fires on every post.
    set_thr(3);
    set_en(4'b1101);
    post(5, g); chk("R4 coalescing off first", g, 4'b0010);
    ack_all();
    post(1, g); chk("R4 coalescing off second", g, 4'b0010);
    ack_all();
    set_en(4'b1111);

    // R2: admin fires vector 0 at once and clears the pending I/O count.
    post(4, g); chk("R2 io pending 1", g, '0);
    post(4, g); chk("R2 io pending 2", g, '0);
    post(0, g); chk("R2 admin immediate", g, 4'b0001);
    ack_all();
    for (int k = 1; k <= 4; k++) begin
      post(4, g);
      chk("R2 count cleared by admin fire", g, (k == 4) ? 4'b0001 : 4'b0000);
    end
    ack_all();

    // R11 and R3: shared vector aggregation, map write, admin entry pinned.
    set_thr(1);
    post(6, g); chk("R11 shared q6", g, '0);
    post(2, g); chk("R11 shared q2 completes", g, 4'b0100);
    ack_all();
    map_wr = 1'b1; map_wr_qid = 3'd3; map_wr_vec = 2'd2;
    @(negedge clk);
    map_wr_qid = 3'd0; map_wr_vec = 2'd3;
    @(negedge clk);
    map_wr = 1'b0;
    post(3, g); chk("R3 remapped q3 counts on v2", g, '0);
    post(6, g); chk("R3 R11 remapped q3 plus q6", g, 4'b0100);
    ack_all();
    post(0, g); chk("R3 admin stays on v0", g, 4'b0001);
    ack_all();
    post(7, g); chk("R3 admin did not count on v3", g, '0);
    post(7, g); chk("R3 v3 second post", g, 4'b1000);
    ack_all();

    // R6: timer of one unit fires exactly TICK edges after the first post.
    set_thr(7);
    set_time(1);
    post(7, g); chk("R6 timer start", g, '0);
    bad = 0;
    for (int k = 1; k <= TICK; k++) begin
      @(negedge clk);
      if (irq_req !== ((k == TICK) ? 4'b1000 : 4'b0000)) bad++;
    end
    chk("R6 timer expiry cycle", (bad == 0) ? 4'b1000 : 4'b0000, 4'b1000);
    ack_all();
    set_time(0);

    // R8: masked vector holds its completion and fires on unmask.
    set_thr(0);
    irq_mask = 4'b0010;
    post(5, g); chk("R8 masked no fire", g, '0);
    repeat (3) @(negedge clk);
    chk("R8 still masked", irq_req, '0);
    irq_mask = '0;
    @(negedge clk);
    chk("R8 fires on unmask", irq_req, 4'b0010);
    ack_all();

    // R7 and R10: in-service vector holds posts until acknowledged.
    post(6, g); chk("R7 fire", g, 4'b0100);
    @(negedge clk);
    chk("R7 one-cycle pulse", irq_req, '0);
    post(6, g); chk("R7 in service no refire", g, '0);
    irq_ack = '1;
    @(negedge clk);
    irq_ack = '0;
    chk("R10 ack edge quiet", irq_req, '0);
    @(negedge clk);
    chk("R10 fires after ack", irq_req, 4'b0100);
    ack_all();

    // R9: threshold change mid-window applies to the next window only.
    set_thr(3);
    post(7, g); chk("R9 window opens thr3", g, '0);
    set_thr(0);
    post(7, g); chk("R9 old threshold kept 2", g, '0);
    post(7, g); chk("R9 old threshold kept 3", g, '0);
    post(7, g); chk("R9 old threshold reached", g, 4'b1000);
    ack_all();
    post(7, g); chk("R9 new threshold next window", g, 4'b1000);
    ack_all();

    finish_run();
  end
endmodule